// File: doc/BRIEF.md
# Masked GPIO Bank with Per-Pin Source Select

This block is a sixteen-pin general-purpose I/O bank that a controller configures through a small write/read register port. Software chooses which pins the fabric drives and what value each software-owned output carries. For each pin it also picks where the output value comes from. Direction writes and software value writes both carry a bit mask, so one write can change some pins and leave the others alone. The source-select write also carries a mask, one bit per pin. The bank produces an output-enable vector and an output-data vector for the pads. It reads back the pad levels after a two-flop synchronizer.

Each output pin has its own four-way multiplexer. The four inputs are the automatic transmit/receive state value, the software value register, debug bus 0 and debug bus 1. A pin configured as an input never drives data.

The bank also sits on a receive sample stream of I and Q words. When streaming is enabled per channel, the synchronized level of one pad replaces the least significant bit of that channel's sample. The stream passes through one register stage, and its valid flag stays aligned with the data.

Top module: `gpio_bank_ss`

## Requirements
- R1: After reset, every register reads 0. `pad_oe_o` and `pad_out_o` are 0, streaming is disabled, all sources select the transition-state input, and `smp_valid_o` is 0.
- R2: A write to address 0 updates the direction bit `dir[p]` only where `wr_mask_i[p]` is 1, taking `wr_data_i[p]`. A value of 1 makes pin p an output. Bits with mask 0 keep their value. `pad_oe_o` equals the direction register.
- R3: A write to address 1 updates the software value bit `val[p]` only where `wr_mask_i[p]` is 1. Other bits keep their value.
- R4: A write to address 2 updates the 2-bit source code of pin p, held at `wr_data_i[2p+1:2p]`, only where `wr_mask_i[p]` is 1. The codes are 00 for `atr_i`, 01 for the software value, 10 for `dbg0_i` and 11 for `dbg1_i`.
- R5: `pad_out_o[p]` equals the source selected for pin p when `dir[p]` is 1, and is 0 when `dir[p]` is 0.
- R6: Reading address 4 returns the pad input levels through two register stages. A change on `pad_in_i` shows up after the second rising clock edge, and not after the first.
- R7: Address 3 holds the 2-bit streaming enable in bits 1:0 and is written without a mask. Reads of addresses 0 to 3 return the register contents in the low bits. Unused addresses read 0.
- R8: With both enable bits 0, `smp_i_o`, `smp_q_o` and `smp_valid_o` equal `smp_i_i`, `smp_q_i` and `smp_valid_i` one clock later.
- R9: When enable bit 0 is 1, bit 0 of the I output is the synchronized level of pad 15. When enable bit 1 is 1, bit 0 of the Q output is the synchronized level of pad 14. The upper sample bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| wr_mask_i | input | 16 | Per-pin update mask for masked registers |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Read data (combinational) |
| atr_i | input | 16 | Automatic transmit/receive state values |
| dbg0_i | input | 16 | Debug bus 0 |
| dbg1_i | input | 16 | Debug bus 1 |
| pad_in_i | input | 16 | Pad input levels |
| pad_oe_o | output | 16 | Pad output enables |
| pad_out_o | output | 16 | Pad output data |
| smp_valid_i | input | 1 | Input sample valid |
| smp_i_i | input | 16 | Input I sample |
| smp_q_i | input | 16 | Input Q sample |
| smp_valid_o | output | 1 | Output sample valid |
| smp_i_o | output | 16 | Output I sample |
| smp_q_o | output | 16 | Output Q sample |

## Verification
The embedded assertions check the following on every cycle:
- Masked direction and value writes keep every unmasked bit.
- Both registers hold steady when they are not addressed.
- No pin configured as an input ever drives a 1.
- The sample valid flag lags its input by exactly one cycle.
- Samples pass through untouched while streaming is off.

Only the directed scenarios can show the rest:
- that the correct source reaches each pin for each code;
- that the readback synchronizer takes two edges and not one;
- that pads 15 and 14 land in the correct channel's least significant bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_DIR  = 3'd0;
    localparam logic [ADDR_W-1:0] A_VAL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_SEL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_STRM = 3'd3;
    localparam logic [ADDR_W-1:0] A_PINS = 3'd4;

    typedef enum logic [1:0] {
        SRC_ATR  = 2'b00,
        SRC_SW   = 2'b01,
        SRC_DBG0 = 2'b10,
        SRC_DBG1 = 2'b11
    } pin_src_e;

endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [2*NPINS-1:0]    wr_data_i,
    input  logic [NPINS-1:0]      wr_mask_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    input  logic [NPINS-1:0]      pins_i,
    output logic [2*NPINS-1:0]    rd_data_o,
    output logic [NPINS-1:0]      dir_o,
    output logic [NPINS-1:0]      val_o,
    output logic [2*NPINS-1:0]    sel_o,
    output logic [1:0]            strm_o
);
    localparam int DW = 2 * NPINS;

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] val;
        logic [DW-1:0]    sel;
        logic [1:0]       strm;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            unique case (wr_addr_i)
                A_DIR:  st_d.dir = (st_q.dir & ~wr_mask_i) | (wr_data_i[NPINS-1:0] & wr_mask_i);
                A_VAL:  st_d.val = (st_q.val & ~wr_mask_i) | (wr_data_i[NPINS-1:0] & wr_mask_i);
                A_SEL: begin
                    for (int p = 0; p < NPINS; p++) begin
                        if (wr_mask_i[p]) st_d.sel[2*p +: 2] = wr_data_i[2*p +: 2];
                    end
                end
                A_STRM: st_d.strm = wr_data_i[1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            A_DIR:  rd_data_o[NPINS-1:0] = st_q.dir;
            A_VAL:  rd_data_o[NPINS-1:0] = st_q.val;
            A_SEL:  rd_data_o            = st_q.sel;
            A_STRM: rd_data_o[1:0]       = st_q.strm;
            A_PINS: rd_data_o[NPINS-1:0] = pins_i;
            default: ;
        endcase
    end

    assign dir_o  = st_q.dir;
    assign val_o  = st_q.val;
    assign sel_o  = st_q.sel;
    assign strm_o = st_q.strm;

    // R2
    dir_mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == A_DIR) |=>
            ((st_q.dir & ~$past(wr_mask_i)) == ($past(st_q.dir) & ~$past(wr_mask_i))));

    // R2
    dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && wr_addr_i == A_DIR) |=> $stable(st_q.dir));

    // R3
    val_mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == A_VAL) |=>
            ((st_q.val & ~$past(wr_mask_i)) == ($past(st_q.val) & ~$past(wr_mask_i))));

    // R3
    val_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && wr_addr_i == A_VAL) |=> $stable(st_q.val));

endmodule

// File: rtl/gpio_bank_outmux.sv
module gpio_bank_outmux
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic [NPINS-1:0]   dir_i,
    input  logic [NPINS-1:0]   val_i,
    input  logic [2*NPINS-1:0] sel_i,
    input  logic [NPINS-1:0]   atr_i,
    input  logic [NPINS-1:0]   dbg0_i,
    input  logic [NPINS-1:0]   dbg1_i,
    output logic [NPINS-1:0]   oe_o,
    output logic [NPINS-1:0]   out_o
);
    logic [NPINS-1:0] src_val;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pin_src_e code;
        assign code = pin_src_e'(sel_i[2*p +: 2]);
        always_comb begin
            unique case (code)
                SRC_ATR:  src_val[p] = atr_i[p];
                SRC_SW:   src_val[p] = val_i[p];
                SRC_DBG0: src_val[p] = dbg0_i[p];
                SRC_DBG1: src_val[p] = dbg1_i[p];
                default:  src_val[p] = 1'b0;
            endcase
        end
    end

    assign oe_o  = dir_i;
    assign out_o = src_val & dir_i;

    // R5
    always_comb begin
        input_pin_quiet_chk: assert ((out_o & ~oe_o) == '0);
    end

endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int NPINS = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPINS-1:0] pad_i,
    output logic [NPINS-1:0] pad_o
);
    typedef struct packed {
        logic [NPINS-1:0] s1;
        logic [NPINS-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = pad_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pad_o = st_q.s2;

endmodule

// File: rtl/gpio_bank_stream.sv
module gpio_bank_stream #(
    parameter int NPINS = 16,
    parameter int SW    = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       en_i,
    input  logic [NPINS-1:0] pins_i,
    input  logic             valid_i,
    input  logic [SW-1:0]    i_i,
    input  logic [SW-1:0]    q_i,
    output logic             valid_o,
    output logic [SW-1:0]    i_o,
    output logic [SW-1:0]    q_o
);
    localparam int PIN_I = NPINS - 1;
    localparam int PIN_Q = NPINS - 2;

    typedef struct packed {
        logic          vld;
        logic [SW-1:0] i;
        logic [SW-1:0] q;
    } smp_t;

    smp_t st_d, st_q;

    always_comb begin
        st_d.vld = valid_i;
        st_d.i   = i_i;
        st_d.q   = q_i;
        if (en_i[0]) st_d.i[0] = pins_i[PIN_I];
        if (en_i[1]) st_d.q[0] = pins_i[PIN_Q];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign valid_o = st_q.vld;
    assign i_o     = st_q.i;
    assign q_o     = st_q.q;

    // R8
    valid_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (valid_o == $past(valid_i)));

    // R8
    passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i == 2'b00) |=> (i_o == $past(i_i) && q_o == $past(q_i)));

    // R9
    upper_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (i_o[SW-1:1] == $past(i_i[SW-1:1]) && q_o[SW-1:1] == $past(q_i[SW-1:1])));

endmodule

// File: rtl/gpio_bank_ss.sv
module gpio_bank_ss
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int SW    = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [2*NPINS-1:0]  wr_data_i,
    input  logic [NPINS-1:0]    wr_mask_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [2*NPINS-1:0]  rd_data_o,
    input  logic [NPINS-1:0]    atr_i,
    input  logic [NPINS-1:0]    dbg0_i,
    input  logic [NPINS-1:0]    dbg1_i,
    input  logic [NPINS-1:0]    pad_in_i,
    output logic [NPINS-1:0]    pad_oe_o,
    output logic [NPINS-1:0]    pad_out_o,
    input  logic                smp_valid_i,
    input  logic [SW-1:0]       smp_i_i,
    input  logic [SW-1:0]       smp_q_i,
    output logic                smp_valid_o,
    output logic [SW-1:0]       smp_i_o,
    output logic [SW-1:0]       smp_q_o
);
    logic [NPINS-1:0]   dir, val, pins_sync;
    logic [2*NPINS-1:0] sel;
    logic [1:0]         strm;

    gpio_bank_sync #(.NPINS(NPINS)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pad_i (pad_in_i),
        .pad_o (pins_sync)
    );

    gpio_bank_regs #(.NPINS(NPINS)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .wr_mask_i(wr_mask_i),
        .rd_addr_i(rd_addr_i),
        .pins_i   (pins_sync),
        .rd_data_o(rd_data_o),
        .dir_o    (dir),
        .val_o    (val),
        .sel_o    (sel),
        .strm_o   (strm)
    );

    gpio_bank_outmux #(.NPINS(NPINS)) u_mux (
        .dir_i (dir),
        .val_i (val),
        .sel_i (sel),
        .atr_i (atr_i),
        .dbg0_i(dbg0_i),
        .dbg1_i(dbg1_i),
        .oe_o  (pad_oe_o),
        .out_o (pad_out_o)
    );

    gpio_bank_stream #(.NPINS(NPINS), .SW(SW)) u_strm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (strm),
        .pins_i (pins_sync),
        .valid_i(smp_valid_i),
        .i_i    (smp_i_i),
        .q_i    (smp_q_i),
        .valid_o(smp_valid_o),
        .i_o    (smp_i_o),
        .q_o    (smp_q_o)
    );

endmodule

// File: tb/gpio_bank_ss_bench.sv
module gpio_bank_ss_bench;
    localparam int NP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] wr_mask = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] atr = '0, dbg0 = '0, dbg1 = '0, pad_in = '0;
    logic [15:0] pad_oe, pad_out;
    logic        s_vld_i = 1'b0;
    logic [15:0] s_i_i = '0, s_q_i = '0;
    logic        s_vld_o;
    logic [15:0] s_i_o, s_q_o;

    int n_chk = 0;
    int n_err = 0;

    logic [15:0] m_dir = '0, m_val = '0, m_pad = '0;
    logic [31:0] m_sel = '0;
    logic [1:0]  m_strm = '0;

    always #10 clk = ~clk;

    gpio_bank_ss u_gpio_bank_ss (
        .clk_i(clk), .rst_ni(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_mask_i(wr_mask),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .atr_i(atr), .dbg0_i(dbg0), .dbg1_i(dbg1), .pad_in_i(pad_in),
        .pad_oe_o(pad_oe), .pad_out_o(pad_out),
        .smp_valid_i(s_vld_i), .smp_i_i(s_i_i), .smp_q_i(s_q_i),
        .smp_valid_o(s_vld_o), .smp_i_o(s_i_o), .smp_q_o(s_q_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [15:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_mask = m;
        @(negedge clk);
        wr_en = 1'b0; wr_mask = '0;
        case (a)
            3'd0: m_dir = (m_dir & ~m) | (d[15:0] & m);
            3'd1: m_val = (m_val & ~m) | (d[15:0] & m);
            3'd2: for (int p = 0; p < NP; p++) if (m[p]) m_sel[2*p +: 2] = d[2*p +: 2];
            3'd3: m_strm = d[1:0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [15:0] exp_out();
        logic [15:0] r;
        for (int p = 0; p < NP; p++) begin
            case (m_sel[2*p +: 2])
                2'b00: r[p] = atr[p];
                2'b01: r[p] = m_val[p];
                2'b10: r[p] = dbg0[p];
                default: r[p] = dbg1[p];
            endcase
        end
        return r & m_dir;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reg read", d, 32'h0);
        end
        chk("R1 oe", {16'h0, pad_oe}, 32'h0);
        chk("R1 out", {16'h0, pad_out}, 32'h0);
        chk("R1 valid", {31'h0, s_vld_o}, 32'h0);
    endtask

    task automatic t_dir();
        logic [31:0] d;
        wr(3'd0, 32'hFFFF, 16'h00FF);
        rd(3'd0, d); chk("R2 dir set low byte", d, 32'h00FF);
        wr(3'd0, 32'h0000, 16'h000F);
        rd(3'd0, d); chk("R2 dir clear nibble", d, 32'h00F0);
        wr(3'd0, 32'hAAAA, 16'hFF00);
        rd(3'd0, d); chk("R2 dir high byte", d, 32'hAAF0);
        chk("R2 oe matches dir", {16'h0, pad_oe}, 32'hAAF0);
        wr(3'd0, 32'h1234, 16'h0000);
        rd(3'd0, d); chk("R2 dir zero mask", d, 32'hAAF0);
    endtask

    task automatic t_val();
        logic [31:0] d;
        wr(3'd1, 32'h5A5A, 16'hF0F0);
        rd(3'd1, d); chk("R3 val masked", d, {16'h0, m_val});
        wr(3'd1, 32'h0FFF, 16'h0F0F);
        rd(3'd1, d); chk("R3 val second", d, 32'h5F5F);
    endtask

    task automatic t_sel();
        logic [31:0] d;
        wr(3'd0, 32'hFFFF, 16'hFFFF);
        atr = 16'hC3A5; dbg0 = 16'h0FF0; dbg1 = 16'h9669;
        #1; chk("R5 all atr", {16'h0, pad_out}, {16'h0, exp_out()});
        wr(3'd2, 32'hE4E4_E4E4, 16'hFFFF);
        rd(3'd2, d); chk("R7 sel read", d, 32'hE4E4_E4E4);
        chk("R4 mixed sources", {16'h0, pad_out}, {16'h0, exp_out()});
        wr(3'd2, 32'hFFFF_FFFF, 16'h00FF);
        rd(3'd2, d); chk("R4 sel masked", d, 32'hE4E4_FFFF);
        chk("R4 dbg1 low pins", {16'h0, pad_out}, {16'h0, exp_out()});
        wr(3'd2, 32'h5555_5555, 16'hFFFF);
        chk("R4 all software", {16'h0, pad_out}, {16'h0, m_val});
        wr(3'd2, 32'hAAAA_AAAA, 16'hFFFF);
        chk("R4 all dbg0", {16'h0, pad_out}, {16'h0, dbg0});
    endtask

    task automatic t_gate();
        wr(3'd0, 32'h0000, 16'h3C3C);
        wr(3'd2, 32'h5555_5555, 16'hFFFF);
        wr(3'd1, 32'hFFFF, 16'hFFFF);
        chk("R5 input pins quiet", {16'h0, pad_out}, {16'h0, m_dir});
        chk("R5 model", {16'h0, pad_out}, {16'h0, exp_out()});
    endtask

    task automatic t_pins();
        logic [31:0] d;
        @(negedge clk); pad_in = 16'h1234;
        @(negedge clk);
        rd(3'd4, d); chk("R6 one edge old", d, {16'h0, m_pad});
        @(negedge clk);
        m_pad = 16'h1234;
        rd(3'd4, d); chk("R6 two edges new", d, 32'h1234);
        rd(3'd5, d); chk("R7 unused addr", d, 32'h0);
    endtask

    task automatic send(input string req, input logic v, input logic [15:0] i, input logic [15:0] q);
        logic [15:0] ei, eq;
        @(negedge clk);
        s_vld_i = v; s_i_i = i; s_q_i = q;
        ei = i; eq = q;
        if (m_strm[0]) ei[0] = m_pad[15];
        if (m_strm[1]) eq[0] = m_pad[14];
        @(negedge clk);
        s_vld_i = 1'b0;
        chk(req, {15'h0, s_vld_o, s_i_o}, {15'h0, v, ei});
        chk(req, {16'h0, s_q_o}, {16'h0, eq});
    endtask

    task automatic t_stream_off();
        send("R8 pass a", 1'b1, 16'h1235, 16'hABCD);
        send("R8 pass b", 1'b0, 16'hFFFF, 16'h0001);
    endtask

    task automatic t_stream_on();
        logic [31:0] d;
        @(negedge clk); pad_in = 16'h8000;
        repeat (3) @(negedge clk);
        m_pad = 16'h8000;
        wr(3'd3, 32'h1, 16'h0);
        rd(3'd3, d); chk("R7 strm read", d, 32'h1);
        send("R9 I lsb from pad15", 1'b1, 16'h4440, 16'h2222);
        wr(3'd3, 32'h2, 16'h0);
        send("R9 Q lsb from pad14 low", 1'b1, 16'h4441, 16'h3333);
        @(negedge clk); pad_in = 16'h4000;
        repeat (3) @(negedge clk);
        m_pad = 16'h4000;
        wr(3'd3, 32'h3, 16'h0);
        send("R9 both channels", 1'b1, 16'h7777, 16'h8888);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_dir();
        t_val();
        t_sel();
        t_gate();
        t_pins();
        t_stream_off();
        t_stream_on();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog got=hang exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule